// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is the per-processor controller of a small direct-mapped cache. The cache writes through and does not allocate on writes, and it sits on a shared bus where transactions are atomic. Each line carries one bit of coherence state, so it is either present and usable or absent. Processor reads that find their line are answered from the local array without touching the bus. Read misses fetch the word over the bus and install it. Every processor write is sent to memory over the bus. When the write targets a line that is held, the local copy is updated at the same time, and the line state does not change.

A separate snoop port watches the transactions that the other caches place on the shared bus. A write from elsewhere to an address this cache holds clears that line, so the next local read goes to memory and sees the new value. While this controller owns the bus, the snoop port shows only its own traffic, and that traffic is ignored. The bus handshake is simple. The controller raises a request and waits for a grant from an external arbiter. It then drives one command (address, direction, write data) and holds it until memory acknowledges. The acknowledge also carries read data. The processor side allows one operation in flight and finishes it with a single-cycle ready pulse.

Top module: `wtc_ctrl`

## Requirements
- R1: After a synchronous reset every line is absent, and bus_req, bus_cmd_valid and cpu_ready are low.
- R2: A read whose line is absent or holds another tag raises bus_req. After grant it issues one read command for cpu_addr. On bus_ack the line is installed with bus_rdata, and cpu_ready pulses with cpu_rdata equal to that bus data.
- R3: A read whose line is present with a matching tag returns the stored word with cpu_ready one clock after the request is first sampled, and it issues no bus traffic.
- R4: Every processor write, hit or miss, issues exactly one bus write with bus_addr = cpu_addr and bus_wdata = cpu_wdata, and completes with cpu_ready after bus_ack.
- R5: A write to a present line replaces the stored word, so a following read hits and returns the written data.
- R6: A write to an absent line installs nothing, so a following read of that address misses and goes to the bus.
- R7: A write observed on the snoop port (obs_valid=1, obs_we=1) while bus_gnt is low, to an address whose line is present with matching tag, clears that line. The next local read of it misses.
- R8: A snooped write to the same line index with a different tag leaves the line present.
- R9: A snooped read (obs_we=0) has no effect on line state.
- R10: Snoop traffic seen while bus_gnt is high, which is the controller's own transaction, never clears a line. A read after its own write to a present line still hits.
- R11: bus_cmd_valid is high only while bus_req and bus_gnt are high.
- R12: cpu_ready is high for exactly one cycle per operation.
- R13: The line index is the low log2(LINES) address bits and the tag is the remaining high bits. A read miss replaces whatever tag the indexed line held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_cmd_valid | output | 1 | Command on bus, held until bus_ack |
| bus_cmd_we | output | 1 | Command direction, 1 = write |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Command write data |
| bus_ack | input | 1 | Memory acknowledge, ends data phase |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| obs_valid | input | 1 | A transaction is visible on the shared bus |
| obs_we | input | 1 | Observed transaction is a write |
| obs_addr | input | ADDR_W | Observed address |

## Verification
A line left present when it should have been cleared shows up as a stale word on the next local read of that address. It also shows up as a missing bus read in the same operation, so one read after the snoop exposes it. A line that is wrongly absent, or wrongly installed by a write, shows as an extra or missing bus read and a latency other than one cycle on the very next access to it. A corrupted stored word shows in cpu_rdata on the next hit. The sweeps compare every read against a memory model and a bench-side copy of the line state, so every such error appears at the first access after it is made.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2,
        ST_RESP = 2'd3
    } wtc_state_e;

    typedef struct packed {
        logic fill;
        logic dwr;
        logic rd_hit;
    } wtc_act_t;

    function automatic logic tag_match(input logic vld, input logic eq);
        return vld & eq;
    endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] p_idx,
    input  logic [TAG_W-1:0] p_tag,
    output logic             p_hit,
    input  logic [IDX_W-1:0] s_idx,
    input  logic [TAG_W-1:0] s_tag,
    output logic             s_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             kill_en,
    input  logic [IDX_W-1:0] kill_idx,
    output logic [LINES-1:0] valid_o
);
    import wtc_pkg::*;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                vld_q[i] <= 1'b1;
                tag_q[i] <= fill_tag;
            end else if (kill_en && kill_idx == IDX_W'(i)) begin
                vld_q[i] <= 1'b0;
            end
        end
    end

    // Two independent lookup ports: processor side and snoop side
    assign p_hit   = tag_match(vld_q[p_idx], tag_q[p_idx] == p_tag);
    assign s_hit   = tag_match(vld_q[s_idx], tag_q[s_idx] == s_tag);
    assign valid_o = vld_q;

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/wtc_seq.sv
module wtc_seq (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic               hit,
    input  logic               bus_gnt,
    input  logic               bus_ack,
    output logic               bus_req,
    output logic               cmd_valid,
    output logic               cpu_ready,
    output wtc_pkg::wtc_act_t  act
);
    import wtc_pkg::*;

    wtc_state_e st_q, st_d;

    always_comb begin
        st_d       = st_q;
        bus_req    = 1'b0;
        cmd_valid  = 1'b0;
        cpu_ready  = 1'b0;
        act        = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_we && hit) begin
                        act.rd_hit = 1'b1;
                        st_d       = ST_RESP;
                    end else begin
                        st_d = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) st_d = ST_XFER;
            end
            ST_XFER: begin
                bus_req   = 1'b1;
                cmd_valid = 1'b1;
                if (bus_ack) begin
                    act.fill = !cpu_we;
                    act.dwr  = !cpu_we || hit;
                    st_d     = ST_RESP;
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                st_d      = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              obs_valid,
    input  logic              obs_we,
    input  logic [ADDR_W-1:0] obs_addr
);
    import wtc_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  p_idx, s_idx;
    logic [TAG_W-1:0]  p_tag, s_tag;
    logic              p_hit, snp_hit, kill_en;
    logic [LINES-1:0]  line_valid;
    logic [DATA_W-1:0] d_rd, d_wr;
    wtc_act_t          act;
    logic [DATA_W-1:0] rdata_q;

    assign p_idx = cpu_addr[IDX_W-1:0];
    assign p_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = obs_addr[IDX_W-1:0];
    assign s_tag = obs_addr[ADDR_W-1:IDX_W];

    // Foreign writes only; while granted the bus carries our own command
    assign kill_en = obs_valid && obs_we && !bus_gnt && snp_hit;

    wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .p_idx    (p_idx),
        .p_tag    (p_tag),
        .p_hit    (p_hit),
        .s_idx    (s_idx),
        .s_tag    (s_tag),
        .s_hit    (snp_hit),
        .fill_en  (act.fill),
        .fill_idx (p_idx),
        .fill_tag (p_tag),
        .kill_en  (kill_en),
        .kill_idx (s_idx),
        .valid_o  (line_valid)
    );

    assign d_wr = cpu_we ? cpu_wdata : bus_rdata;

    wtc_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (act.dwr),
        .wr_idx  (p_idx),
        .wr_data (d_wr),
        .rd_idx  (p_idx),
        .rd_data (d_rd)
    );

    wtc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .hit       (p_hit),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .bus_req   (bus_req),
        .cmd_valid (bus_cmd_valid),
        .cpu_ready (cpu_ready),
        .act       (act)
    );

    always_ff @(posedge clk) begin
        if (rst)              rdata_q <= '0;
        else if (act.rd_hit)  rdata_q <= d_rd;
        else if (act.fill)    rdata_q <= bus_rdata;
    end

    // Processor holds its request stable, so command fields come straight through
    assign bus_cmd_we = cpu_we;
    assign bus_addr   = cpu_addr;
    assign bus_wdata  = cpu_wdata;
    assign cpu_rdata  = rdata_q;

endmodule

// File: rtl/wtc_ctrl_chk.sv
module wtc_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_cmd_valid,
    input logic              bus_cmd_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              obs_valid,
    input logic              obs_we,
    input logic [ADDR_W-1:0] obs_addr,
    input logic              snp_hit,
    input logic [LINES-1:0]  line_valid
);

    // R11
    cmd_needs_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |-> (bus_gnt && bus_req));

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R4
    wr_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_valid && bus_cmd_we) |-> (bus_addr == cpu_addr && bus_wdata == cpu_wdata));

    // R7
    snoop_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (obs_valid && obs_we && !bus_gnt && snp_hit)
            |=> !line_valid[$past(obs_addr[IDX_W-1:0])]);

    // R6
    no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_valid && bus_cmd_we && bus_ack)
            |=> $countones(line_valid) <= $past($countones(line_valid)));

    // R10
    own_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && bus_cmd_valid)
            |=> $countones(line_valid) >= $past($countones(line_valid)));

endmodule

bind wtc_ctrl wtc_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_ready     (cpu_ready),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd_we    (bus_cmd_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_ack       (bus_ack),
    .obs_valid     (obs_valid),
    .obs_we        (obs_we),
    .obs_addr      (obs_addr),
    .snp_hit       (snp_hit),
    .line_valid    (line_valid)
);

// File: tb/sim_wtc_ctrl.sv
module sim_wtc_ctrl;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int NL = 4;
    localparam int IW = 2;
    localparam int NA = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, bus_req, bus_cmd_valid, bus_cmd_we;
    logic [DW-1:0] cpu_rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 0, bus_ack = 0;
    logic [DW-1:0] bus_rdata = '0;
    logic          inj_v = 0, inj_we = 0, mv = 0, mw = 0;
    logic [AW-1:0] inj_a = '0, ma = '0;
    logic          obs_valid, obs_we;
    logic [AW-1:0] obs_addr;

    assign obs_valid = inj_v | mv;
    assign obs_we    = inj_v ? inj_we : mw;
    assign obs_addr  = inj_v ? inj_a : ma;

    wtc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_we(bus_cmd_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .obs_valid(obs_valid),
        .obs_we(obs_we), .obs_addr(obs_addr)
    );

    int n_tests = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_viol = 0;
    logic [DW-1:0] mem [NA];
    logic [AW-1:0] last_wa;
    logic [DW-1:0] last_wd;
    logic          ev [NL];
    logic [AW-IW-1:0] et [NL];
    int            lat = 0;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Bus model: arbiter grants one cycle after request, memory acks after one wait cycle
    always @(negedge clk) begin
        if (rst) begin
            bus_gnt <= 0; bus_ack <= 0; lat = 0; mv <= 0;
        end else begin
            bus_gnt <= bus_req;
            mv <= bus_cmd_valid; mw <= bus_cmd_we; ma <= bus_addr;
            if (bus_cmd_valid && !(bus_gnt && bus_req)) n_viol++;
            if (bus_ack) begin
                bus_ack <= 0; lat = 0;
            end else if (bus_cmd_valid) begin
                if (lat == 1) begin
                    bus_ack <= 1;
                    if (bus_cmd_we) begin
                        mem[bus_addr] = bus_wdata; n_wr++;
                        last_wa = bus_addr; last_wd = bus_wdata;
                    end else begin
                        bus_rdata <= mem[bus_addr]; n_rd++;
                    end
                end else lat++;
            end
        end
    end

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input string rq);
        int idx = int'(a[IW-1:0]);
        bit hit = ev[idx] && et[idx] == a[AW-1:IW];
        int rd0 = n_rd, wr0 = n_wr, cyc = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do begin
            @(posedge clk); #1; cyc++;
        end while (!cpu_ready && cyc < 50);
        check(cpu_ready == 1, {rq, " ready"}, cyc, 0);
        if (!we) begin
            check(cpu_rdata == mem[a], {rq, " rdata"}, cpu_rdata, mem[a]);
            check((n_rd - rd0) == (hit ? 0 : 1), {rq, " bus reads"}, n_rd - rd0, hit ? 0 : 1);
            if (hit) check(cyc == 1, {rq, " R3 hit latency"}, cyc, 1);
            if (!hit) begin ev[idx] = 1; et[idx] = a[AW-1:IW]; end
        end else begin
            check((n_wr - wr0) == 1 && last_wa == a && last_wd == wd,
                  {rq, " R4 bus write"}, {last_wa, last_wd}, {a, wd});
            check(n_rd == rd0, {rq, " R4 no bus read"}, n_rd - rd0, 0);
        end
        @(negedge clk);
        cpu_req = 0;
        @(posedge clk); #1;
        check(cpu_ready == 0, "R12 ready pulse", cpu_ready, 0);
    endtask

    task automatic foreign(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int idx = int'(a[IW-1:0]);
        @(negedge clk);
        inj_v = 1; inj_we = we; inj_a = a;
        if (we) begin
            mem[a] = wd;
            if (ev[idx] && et[idx] == a[AW-1:IW]) ev[idx] = 0;
        end
        @(posedge clk);
        @(negedge clk);
        inj_v = 0;
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int a = 0; a < NA; a++) mem[a] = DW'(a * 1237 + 91);
        for (int i = 0; i < NL; i++) begin ev[i] = 0; et[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1
        check(bus_req == 0 && bus_cmd_valid == 0 && cpu_ready == 0, "R1 reset outputs",
              {bus_req, bus_cmd_valid, cpu_ready}, 0);
        cpu_op(0, 5'd3, '0, "R1 first read misses");

        // R2, R3, R13: every address, miss then hit, sweeping conflicting tags
        for (int a = 0; a < NA; a++) begin
            cpu_op(0, AW'(a), '0, "R2 R13 read fill");
            cpu_op(0, AW'(a), '0, "R3 read hit");
        end

        // R4, R5, R6, R10: write hit and write miss on each address
        for (int a = 0; a < NA; a++) begin
            if (a % 2 == 0) cpu_op(0, AW'(a), '0, "R5 prefill");
            cpu_op(1, AW'(a), DW'(a * 77 + 1), a % 2 == 0 ? "R5 write hit" : "R6 write miss");
            cpu_op(0, AW'(a), '0, a % 2 == 0 ? "R5 R10 read after own write" : "R6 read after write miss");
        end

        // R7, R8, R9: snoop on each address
        for (int a = 0; a < NA; a++) begin
            cpu_op(0, AW'(a), '0, "R7 prefill");
            foreign(0, AW'(a), '0);
            cpu_op(0, AW'(a), '0, "R9 snooped read ignored");
            foreign(1, AW'((a + NL) % NA), DW'(a * 5 + 3));
            cpu_op(0, AW'(a), '0, "R8 other tag ignored");
            foreign(1, AW'(a), DW'(a * 9 + 7));
            cpu_op(0, AW'(a), '0, "R7 snooped write invalidates");
        end

        // Mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0])
                2'd0, 2'd1: cpu_op(0, lf[AW+1:2], '0, "R2 R3 R7 mixed read");
                2'd2:       cpu_op(1, lf[AW+1:2], lf ^ 16'h5A5A, "R4 R5 mixed write");
                default:    foreign(lf[8], lf[AW+1:2], lf ^ 16'h3C3C);
            endcase
        end

        check(n_viol == 0, "R11 command without grant", n_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule